// File: doc/BRIEF.md
# Serial Lock Quality Monitor

This block watches the bit stream coming out of a clock-recovery front end and decides whether the receiver can trust the recovered clock or must fall back to the local reference. It looks at two statistics only. The first is the length of the current run of identical bits. The second is the number of transitions counted in fixed, back-to-back windows of valid bits. A bit-valid strobe qualifies every sample. On any cycle where the strobe is low, nothing is counted.

When the recovered data is clean for a fixed number of consecutive valid bits, the monitor declares lock to the data. Its active-low lock flag then goes low. A run that grows too long, or a window with too few transitions, sends it back to reference mode, and clean bits are counted again from zero. A single slipped or doubled bit, which is what a phase jump looks like at this level, breaks neither statistic, so it does not drop lock. An active-low force input holds the block in reference mode and clears all data statistics. A separate registered output selects the clock source for the downstream clock multiplexer. It follows the lock flag only on cycles marked as word boundaries, so the switch between clock sources never cuts a word clock short.

Top module: `lkm_lock_monitor`

## Requirements
- R1: While `force_ref_n` is high, a valid bit that extends a run of identical valid bits to more than RUN_LIMIT (default 64) bits is a violation, so `lock_n` is high after that clock edge. A run of exactly RUN_LIMIT bits is not a violation.
- R2: Valid bits are grouped into consecutive windows of WIN_LEN (default 256), and the first window starts at the first valid bit after reset or after the force input is released. A transition is a valid bit whose value differs from the previous valid bit; the first bit after reset or release is not a transition. When a window closes with fewer than MIN_TRANS (default 31) transitions, that is a violation and `lock_n` is high after the edge of the window's last bit. Exactly MIN_TRANS transitions is not a violation.
- R3: In reference mode, `lock_n` goes low on the clock edge that takes in the ACQ_LEN-th (default 250) consecutive valid bit with no violation. Any violation sets that count back to zero.
- R4: A single doubled bit inserted into otherwise alternating data, as seen after a phase jump, leaves `lock_n` low.
- R5: After reset, `lock_n` is 1 and `use_ref` is 1.
- R6: While `force_ref_n` is 0, `lock_n` is 1 from the next clock edge onward and serial data is ignored. After release, lock needs a full ACQ_LEN clean bits again.
- R7: `use_ref` is registered. On a clock edge where `word_end` is 1, it takes the value `lock_n` had before that edge. On any other edge it holds its value.
- R8: On cycles with `bit_vld` low, `bit_in` is ignored. Such cycles neither count toward acquisition nor break or extend runs, and `lock_n` does not change on them unless the force input is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Qualifies `bit_in` on this cycle |
| bit_in | input | 1 | Recovered serial data bit |
| force_ref_n | input | 1 | Active low: hold reference mode and ignore the data |
| word_end | input | 1 | Marks a word boundary, the only point where `use_ref` may change |
| lock_n | output | 1 | Active low: locked to the data; high means running from the reference |
| use_ref | output | 1 | Clock-source select for the downstream multiplexer, 1 = reference |

## Verification
The checker watches the following on every cycle:
- an over-long run always leaves the lock flag high;
- the force input always wins;
- idle cycles never move the lock flag;
- the clock-source select moves only at word boundaries and then copies the lock flag.

Some behaviours need whole bit sequences and only the bench scenarios can show them:
- the exact acquisition count and its restart;
- the density decision at the end of a window, including the exactly-at-threshold case;
- tolerance of a slipped bit.

Between scenarios, a behavioural model in the bench compares both outputs on every clock.

// File: rtl/lkm_pkg.sv
package lkm_pkg;
   typedef enum logic {
      LK_REF  = 1'b0,
      LK_DATA = 1'b1
   } lk_state_e;
endpackage

// File: rtl/lkm_run_tracker.sv
module lkm_run_tracker #(
   parameter int RUN_LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic vld,
   input  logic bit_in,
   output logic trans,
   output logic run_viol
);
   localparam int RW = $clog2(RUN_LIMIT + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LIMIT);
   localparam logic [RW-1:0] RUN_ONE = RW'(1);

   logic          prev_bit;
   logic          have_prev;
   logic [RW-1:0] run_cnt;
   logic          same;

   assign same     = have_prev & (bit_in == prev_bit);
   assign trans    = vld & have_prev & (bit_in != prev_bit);
   assign run_viol = vld & same & (run_cnt >= RUN_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_bit  <= 1'b0;
         have_prev <= 1'b0;
         run_cnt   <= '0;
      end else if (clr) begin
         have_prev <= 1'b0;
         run_cnt   <= '0;
      end else if (vld) begin
         prev_bit  <= bit_in;
         have_prev <= 1'b1;
         if (same)
            run_cnt <= (run_cnt >= RUN_MAX) ? run_cnt : run_cnt + RUN_ONE;
         else
            run_cnt <= RUN_ONE;
      end
   end
endmodule

// File: rtl/lkm_density_window.sv
module lkm_density_window #(
   parameter int WIN_LEN   = 256,
   parameter int MIN_TRANS = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic vld,
   input  logic trans,
   output logic dens_viol
);
   localparam int PW = $clog2(WIN_LEN);
   localparam int TW = $clog2(WIN_LEN + 1);
   localparam logic [PW-1:0] POS_LAST = PW'(WIN_LEN - 1);
   localparam logic [PW-1:0] POS_ONE  = PW'(1);
   localparam logic [TW-1:0] T_MIN    = TW'(MIN_TRANS);

   logic [PW-1:0] pos;
   logic [TW-1:0] tcnt;
   logic [TW-1:0] total;
   logic          last;

   assign last      = (pos == POS_LAST);
   assign total     = tcnt + TW'(trans);
   assign dens_viol = vld & last & (total < T_MIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos  <= '0;
         tcnt <= '0;
      end else if (clr) begin
         pos  <= '0;
         tcnt <= '0;
      end else if (vld) begin
         if (last) begin
            pos  <= '0;
            tcnt <= '0;
         end else begin
            pos  <= pos + POS_ONE;
            tcnt <= total;
         end
      end
   end
endmodule

// File: rtl/lkm_lock_fsm.sv
module lkm_lock_fsm
   import lkm_pkg::*;
#(
   parameter int ACQ_LEN = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_ref,
   input  logic vld,
   input  logic viol,
   output logic locked
);
   localparam int AW = $clog2(ACQ_LEN + 1);
   localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_LEN - 1);
   localparam logic [AW-1:0] ACQ_ONE  = AW'(1);

   lk_state_e     state;
   logic [AW-1:0] clean_cnt;

   assign locked = (state == LK_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= LK_REF;
         clean_cnt <= '0;
      end else if (force_ref) begin
         state     <= LK_REF;
         clean_cnt <= '0;
      end else if (vld) begin
         if (viol) begin
            state     <= LK_REF;
            clean_cnt <= '0;
         end else if (state == LK_REF) begin
            if (clean_cnt == ACQ_LAST) begin
               state     <= LK_DATA;
               clean_cnt <= '0;
            end else begin
               clean_cnt <= clean_cnt + ACQ_ONE;
            end
         end
      end
   end
endmodule

// File: rtl/lkm_lock_monitor.sv
module lkm_lock_monitor #(
   parameter int RUN_LIMIT    = 64,
   parameter int WIN_LEN      = 256,
   parameter int MIN_TRANS    = 31,
   parameter int ACQ_LEN      = 250,
   parameter bit SYNC_TO_WORD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic force_ref_n,
   input  logic word_end,
   output logic lock_n,
   output logic use_ref
);
   if (RUN_LIMIT < 1) begin : g_bad_run
      $error("RUN_LIMIT must be at least 1");
   end
   if (WIN_LEN < 2 || MIN_TRANS > WIN_LEN) begin : g_bad_win
      $error("WIN_LEN must be >= 2 and MIN_TRANS <= WIN_LEN");
   end
   if (ACQ_LEN < 1) begin : g_bad_acq
      $error("ACQ_LEN must be at least 1");
   end

   logic force_ref;
   logic trans;
   logic run_viol;
   logic dens_viol;
   logic locked;

   assign force_ref = ~force_ref_n;

   lkm_run_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_run (
      .clk(clk), .rst_n(rst_n), .clr(force_ref), .vld(bit_vld),
      .bit_in(bit_in), .trans(trans), .run_viol(run_viol)
   );

   lkm_density_window #(.WIN_LEN(WIN_LEN), .MIN_TRANS(MIN_TRANS)) u_win (
      .clk(clk), .rst_n(rst_n), .clr(force_ref), .vld(bit_vld),
      .trans(trans), .dens_viol(dens_viol)
   );

   lkm_lock_fsm #(.ACQ_LEN(ACQ_LEN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .force_ref(force_ref), .vld(bit_vld),
      .viol(run_viol | dens_viol), .locked(locked)
   );

   assign lock_n = ~locked;

   if (SYNC_TO_WORD) begin : g_word_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        use_ref <= 1'b1;
         else if (word_end) use_ref <= lock_n;
      end
   end else begin : g_free_run
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) use_ref <= 1'b1;
         else        use_ref <= lock_n;
      end
   end
endmodule

// File: rtl/lkm_lock_monitor_chk.sv
module lkm_lock_monitor_chk #(
   parameter int RUN_LIMIT    = 64,
   parameter bit SYNC_TO_WORD = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_vld,
   input logic bit_in,
   input logic force_ref_n,
   input logic word_end,
   input logic lock_n,
   input logic use_ref
);
   int   obs_run;
   logic obs_prev;
   logic obs_have;
   logic obs_same;

   assign obs_same = obs_have && (bit_in == obs_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_run  <= 0;
         obs_prev <= 1'b0;
         obs_have <= 1'b0;
      end else if (!force_ref_n) begin
         obs_run  <= 0;
         obs_have <= 1'b0;
      end else if (bit_vld) begin
         obs_prev <= bit_in;
         obs_have <= 1'b1;
         if (!obs_same)               obs_run <= 1;
         else if (obs_run <= RUN_LIMIT) obs_run <= obs_run + 1;
      end
   end

   assert_long_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (force_ref_n && bit_vld && obs_same && obs_run >= RUN_LIMIT) |=> lock_n);

   assert_lock_needs_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_n) |-> $past(bit_vld && force_ref_n));

   assert_force_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !force_ref_n |=> lock_n);

   assert_select_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_TO_WORD && !word_end) |=> $stable(use_ref));

   assert_select_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word_end |=> (use_ref == $past(lock_n)));

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (force_ref_n && !bit_vld) |=> $stable(lock_n));
endmodule

bind lkm_lock_monitor lkm_lock_monitor_chk #(
   .RUN_LIMIT(RUN_LIMIT), .SYNC_TO_WORD(SYNC_TO_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
   .force_ref_n(force_ref_n), .word_end(word_end),
   .lock_n(lock_n), .use_ref(use_ref)
);

// File: tb/lkm_lock_monitor_test.sv
module lkm_lock_monitor_test;
   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic force_ref_n = 1'b1;
   logic word_end = 1'b0;
   logic lock_n;
   logic use_ref;

   int    n_checks = 0;
   int    n_errors = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R5";

   // behavioural reference model
   int m_run, m_pos, m_tcnt, m_clean;
   bit m_prev, m_have, m_locked;
   bit m_lockn = 1'b1;
   bit m_useref = 1'b1;

   always #(PERIOD/2) clk = ~clk;

   lkm_lock_monitor uut (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .force_ref_n(force_ref_n), .word_end(word_end),
      .lock_n(lock_n), .use_ref(use_ref)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_pos = 0; m_tcnt = 0; m_clean = 0;
         m_have = 0; m_locked = 0; m_lockn = 1; m_useref = 1;
      end else begin
         if (word_end) m_useref = m_lockn;
         if (!force_ref_n) begin
            m_locked = 0; m_clean = 0; m_have = 0;
            m_run = 0; m_pos = 0; m_tcnt = 0;
         end else if (bit_vld) begin
            bit t, bad;
            t = m_have && (bit_in != m_prev);
            m_run = (t || !m_have) ? 1 : m_run + 1;
            bad = (m_run > 64);
            m_tcnt += t;
            m_pos++;
            if (m_pos == 256) begin
               if (m_tcnt < 31) bad = 1;
               m_pos = 0; m_tcnt = 0;
            end
            m_prev = bit_in; m_have = 1;
            if (bad) begin
               m_locked = 0; m_clean = 0;
            end else if (!m_locked) begin
               m_clean++;
               if (m_clean == 250) begin m_locked = 1; m_clean = 0; end
            end
         end
         m_lockn = !m_locked;
      end
   end

   task automatic check(string req, logic got, logic exp, string what);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, what, got, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (!done && cyc > 0) begin
         check(cur_req, lock_n, m_lockn, "model lock_n");
         check("R7", use_ref, m_useref, "model use_ref");
      end
   end

   // we < 0: word boundary every tenth cycle
   task automatic send_bit(logic b, logic v, int we);
      @(negedge clk);
      bit_in = b; bit_vld = v;
      word_end = (we < 0) ? ((cyc % 10) == 9) : (we != 0);
      cyc++;
      @(posedge clk); #1;
   endtask

   task automatic send_alt(int n, logic first);
      for (int i = 0; i < n; i++) send_bit(first ^ logic'(i & 1), 1'b1, -1);
   endtask

   task automatic send_runs(int n, int run);
      for (int i = 0; i < n; i++) send_bit(logic'((i / run) & 1), 1'b1, -1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; bit_vld = 0; force_ref_n = 1; word_end = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      cyc++;
   endtask

   initial begin
      do_reset();
      cur_req = "R5";
      check("R5", lock_n, 1'b1, "lock_n after reset");
      check("R5", use_ref, 1'b1, "use_ref after reset");

      // acquisition count
      cur_req = "R3";
      send_alt(249, 1'b0);
      check("R3", lock_n, 1'b1, "still unlocked after 249 clean bits");
      send_alt(1, 1'b1);
      check("R3", lock_n, 1'b0, "locked after 250 clean bits");
      // word-boundary clock select
      cur_req = "R7";
      for (int i = 0; i < 12; i++) send_bit(logic'(i & 1), 1'b1, 0);
      check("R7", use_ref, 1'b1, "use_ref held without word_end");
      send_bit(1'b0, 1'b1, 1);
      check("R7", use_ref, 1'b0, "use_ref switched at word_end");

      // phase jump: doubled bit
      cur_req = "R4";
      send_bit(1'b0, 1'b1, -1);
      send_alt(20, 1'b1);
      check("R4", lock_n, 1'b0, "lock kept across doubled bit");

      // run limit
      do_reset();
      cur_req = "R1";
      send_alt(260, 1'b0);
      for (int i = 0; i < 64; i++) send_bit(1'b0, 1'b1, -1);
      check("R1", lock_n, 1'b0, "run of 64 keeps lock");
      send_bit(1'b0, 1'b1, -1);
      check("R1", lock_n, 1'b1, "run of 65 drops lock");

      // violation restarts acquisition
      cur_req = "R3";
      send_alt(249, 1'b1);
      check("R3", lock_n, 1'b1, "249 clean bits after violation");
      send_alt(1, 1'b0);
      check("R3", lock_n, 1'b0, "250 clean bits after violation");

      // density: runs of 10 -> 25 transitions
      do_reset();
      cur_req = "R2";
      send_runs(255, 10);
      check("R2", lock_n, 1'b0, "locked before window close");
      send_bit(1'b1, 1'b1, -1);
      check("R2", lock_n, 1'b1, "25 transitions drop lock");
      // runs of 9 -> 28 transitions
      do_reset();
      send_runs(256, 9);
      check("R2", lock_n, 1'b1, "28 transitions drop lock");
      // runs of 8 -> exactly 31 transitions
      do_reset();
      send_runs(256, 8);
      check("R2", lock_n, 1'b0, "31 transitions keep lock");

      // force reference
      do_reset();
      cur_req = "R6";
      send_alt(250, 1'b0);
      check("R6", lock_n, 1'b0, "locked before force");
      force_ref_n = 0;
      send_bit(1'b0, 1'b1, -1);
      check("R6", lock_n, 1'b1, "force drops lock");
      send_alt(300, 1'b1);
      check("R6", lock_n, 1'b1, "data ignored while forced");
      force_ref_n = 1;
      send_alt(249, 1'b0);
      check("R6", lock_n, 1'b1, "re-acquire needs full count");
      send_alt(1, 1'b1);
      check("R6", lock_n, 1'b0, "re-acquired after release");

      // idle cycles ignored
      do_reset();
      cur_req = "R8";
      for (int i = 0; i < 249; i++) begin
         send_bit(logic'(i & 1), 1'b1, -1);
         send_bit(1'b1, 1'b0, -1);
         send_bit(1'b1, 1'b0, -1);
      end
      check("R8", lock_n, 1'b1, "idle cycles not counted");
      for (int i = 0; i < 80; i++) send_bit(1'b1, 1'b0, -1);
      check("R8", lock_n, 1'b1, "idle run of ones ignored");
      send_bit(1'b1, 1'b1, -1);
      check("R8", lock_n, 1'b0, "locked on 250th valid bit");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule